// File: doc/BRIEF.md
# Dual-Slot Packet Stream Splitter

This block sits on the receive side of a wide packet interface. Each input beat is 512 bits wide and is made of two 256-bit halves. Every half has its own valid, start and end flag, its own count of unused dwords, a 3-bit region code and function tags. A packet can begin only at the bottom of the word or at its midpoint. It can begin at the midpoint only when another packet finishes in the lower half of the same beat.

The block turns this into a 256-bit stream that carries one half per output beat, always lower half before upper half. A beat that holds the end of one packet and the start of the next is emitted over two cycles, so the two packets never share an output beat. The region code and the function tags given at a packet's start are held in the block and repeated on every output beat of that packet. Downstream logic can therefore route each beat without tracking packet boundaries itself. The output is a plain valid/ready stream, and input acceptance stalls whenever a buffered two-half beat still needs a second output cycle.

Top module: `dual_slot_splitter`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Every input half whose valid bit is set (bit 0 = data[255:0], bit 1 = data[511:256]) appears exactly once as `out_data`. The lower half of a beat always leaves before the upper half of the same beat.
- R3: In the cycle after the block accepts a beat with both valid bits set, `in_ready` is 0. This holds the input for the extra output cycle.
- R4: `out_sop` and `out_eop` copy the start and end flag of the half being emitted. An upper-half start is accepted only together with a lower-half valid end in the same beat.
- R5: When `out_eop` is 1, `out_empty` equals the empty field of the emitted half: in_empty[2:0] for the lower half, in_empty[5:3] for the upper half. When `out_eop` is 0, `out_empty` is 0.
- R6: The region code and function tags are taken from the half that carries the packet start. Region codes are 0–5 for memory regions, 6 for the I/O region and 7 for the expansion ROM region; lower-half fields sit in the low bits of each input vector. These values are repeated unchanged on every output beat of the packet.
- R7: Region codes and function tags presented on a half whose start flag is clear have no effect on any output.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and every output field stays unchanged.
- R9: Under any pattern of downstream backpressure, no half is lost, duplicated or reordered, and output starts and ends alternate correctly.
- R10: A half whose valid bit is clear is never emitted, whatever its data and flags hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 2 | Per-half valid (bit 0 lower, bit 1 upper) |
| in_sop | input | 2 | Per-half packet start |
| in_eop | input | 2 | Per-half packet end |
| in_data | input | 512 | Wide input word |
| in_empty | input | 6 | Unused dwords per half, [2:0] lower, [5:3] upper |
| in_region | input | 6 | Region code per half, [2:0] lower, [5:3] upper |
| in_pf | input | 4 | Physical function number per half, [1:0] lower |
| in_vf_active | input | 2 | Virtual function target flag per half |
| in_vf_num | input | 22 | Virtual function number per half, [10:0] lower |
| in_ready | output | 1 | Input beat accepted when high together with any valid bit |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_data | output | 256 | Output half |
| out_sop | output | 1 | Output beat starts a packet |
| out_eop | output | 1 | Output beat ends a packet |
| out_empty | output | 3 | Unused dwords on an end beat, 0 otherwise |
| out_region | output | 3 | Region code of the current packet |
| out_pf | output | 2 | Physical function number of the current packet |
| out_vf_active | output | 1 | Virtual function flag of the current packet |
| out_vf_num | output | 11 | Virtual function number of the current packet |

## Verification
The assertions check the following on every cycle:
- the output holds steady under backpressure;
- input is stalled for one cycle after a two-half beat;
- the input obeys the upper-half start rule;
- output starts and ends alternate;
- beats after the start repeat the tags seen at the start.

Only the bench's scenarios can show the rest. These are the exact order and content of the emitted halves, the dropping of invalid halves, and that stray tags and empty counts on non-start and non-end halves never leak out. The bench shows this by comparing every output beat against a queue-based model under several backpressure levels.

// File: rtl/dual_slot_splitter.sv
module dual_slot_splitter #(
  parameter int HALF_W   = 256,
  parameter int EMPTY_W  = 3,
  parameter int REGION_W = 3,
  parameter int PF_W     = 2,
  parameter int VF_W     = 11
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            in_valid,
  input  logic [1:0]            in_sop,
  input  logic [1:0]            in_eop,
  input  logic [2*HALF_W-1:0]   in_data,
  input  logic [2*EMPTY_W-1:0]  in_empty,
  input  logic [2*REGION_W-1:0] in_region,
  input  logic [2*PF_W-1:0]     in_pf,
  input  logic [1:0]            in_vf_active,
  input  logic [2*VF_W-1:0]     in_vf_num,
  output logic                  in_ready,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [HALF_W-1:0]     out_data,
  output logic                  out_sop,
  output logic                  out_eop,
  output logic [EMPTY_W-1:0]    out_empty,
  output logic [REGION_W-1:0]   out_region,
  output logic [PF_W-1:0]       out_pf,
  output logic                  out_vf_active,
  output logic [VF_W-1:0]       out_vf_num
);
  localparam int TAG_W = REGION_W + PF_W + 1 + VF_W;

  logic [1:0]         pend;
  logic [HALF_W-1:0]  buf_data  [2];
  logic [EMPTY_W-1:0] buf_empty [2];
  logic [TAG_W-1:0]   buf_tag   [2];
  logic [TAG_W-1:0]   in_tag    [2];
  logic [1:0]         buf_sop, buf_eop;
  logic [TAG_W-1:0]   cur_tag, sel_tag;
  logic               sel, fire, accept;

  always_comb
    for (int h = 0; h < 2; h++)
      in_tag[h] = {in_region[h*REGION_W +: REGION_W], in_pf[h*PF_W +: PF_W],
                   in_vf_active[h], in_vf_num[h*VF_W +: VF_W]};

  assign sel       = ~pend[0];
  assign out_valid = |pend;
  assign fire      = out_valid & out_ready;
  assign in_ready  = (pend != 2'b11) && (pend == 2'b00 || out_ready);
  assign accept    = in_ready & (|in_valid);

  assign out_data  = buf_data[sel];
  assign out_sop   = buf_sop[sel];
  assign out_eop   = buf_eop[sel];
  assign out_empty = out_eop ? buf_empty[sel] : '0;
  assign sel_tag   = out_sop ? buf_tag[sel] : cur_tag;
  assign {out_region, out_pf, out_vf_active, out_vf_num} = sel_tag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend    <= '0;
      cur_tag <= '0;
    end else begin
      if (accept)    pend      <= in_valid;
      else if (fire) pend[sel] <= 1'b0;
      if (fire && out_sop) cur_tag <= sel_tag;
    end
  end

  always_ff @(posedge clk)
    if (accept) begin
      buf_sop <= in_sop;
      buf_eop <= in_eop;
      for (int h = 0; h < 2; h++) begin
        buf_data[h]  <= in_data[h*HALF_W +: HALF_W];
        buf_empty[h] <= in_empty[h*EMPTY_W +: EMPTY_W];
        buf_tag[h]   <= in_tag[h];
      end
    end

  logic             open_q;
  logic [TAG_W-1:0] seen_tag;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q   <= 1'b0;
      seen_tag <= '0;
    end else if (fire) begin
      open_q <= !out_eop;
      if (out_sop) seen_tag <= {out_region, out_pf, out_vf_active, out_vf_num};
    end
  end

  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop)
      && $stable(out_eop) && $stable(out_empty) && $stable(out_region));

  p_pair_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && in_valid == 2'b11 |=> !in_ready);

  p_upper_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && in_valid[1] && in_sop[1] |-> in_valid[0] && in_eop[0]);

  p_sop_closed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sop |-> !open_q);

  p_cont_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_sop |-> open_q);

  p_tag_repeat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_sop && open_q |->
      {out_region, out_pf, out_vf_active, out_vf_num} == seen_tag);
endmodule

// File: tb/dual_slot_splitter_test.sv
module dual_slot_splitter_test;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [1:0]   in_valid, in_sop, in_eop, in_vf_active;
  logic [511:0] in_data;
  logic [5:0]   in_empty, in_region;
  logic [3:0]   in_pf;
  logic [21:0]  in_vf_num;
  logic         in_ready, out_valid, out_ready, out_sop, out_eop, out_vf_active;
  logic [255:0] out_data;
  logic [2:0]   out_empty, out_region;
  logic [1:0]   out_pf;
  logic [10:0]  out_vf_num;

  dual_slot_splitter uut (.*);

  typedef struct packed {
    logic [255:0] d; logic s; logic e; logic [2:0] emp;
    logic [16:0] tag;
  } beat_t;
  beat_t exp_q[$];

  int checks = 0, errors = 0, pkts_left = 0, rem = 0, rdy_pct = 100;
  logic [16:0] pkt_tag;
  bit have_beat, done;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [255:0] rnd256();
    return {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic logic [16:0] rnd17();
    logic [31:0] t = $urandom;
    return t[16:0];
  endfunction

  task automatic put_tag(input int h, input logic [16:0] t);
    in_region[h*3 +: 3]  = t[16:14];
    in_pf[h*2 +: 2]      = t[13:12];
    in_vf_active[h]      = t[11];
    in_vf_num[h*11 +: 11] = t[10:0];
  endtask

  task automatic garbage_half(input int h);
    logic [31:0] t = $urandom;
    in_valid[h] = 1'b0;
    in_sop[h] = t[0];
    in_eop[h] = t[1];
    in_empty[h*3 +: 3] = t[4:2];
    in_data[h*256 +: 256] = rnd256();
    put_tag(h, rnd17());
  endtask

  task automatic start_pkt();
    rem = 1 + int'($urandom % 6);
    pkt_tag = rnd17();
    pkts_left--;
  endtask

  task automatic fill_half(input int h, input bit st);
    beat_t b;
    logic [31:0] t = $urandom;
    b.d = rnd256();
    b.s = st;
    rem--;
    b.e = (rem == 0);
    b.emp = b.e ? t[2:0] : 3'd0;
    b.tag = pkt_tag;
    in_valid[h] = 1'b1;
    in_sop[h] = st;
    in_eop[h] = b.e;
    in_data[h*256 +: 256] = b.d;
    in_empty[h*3 +: 3] = b.e ? t[2:0] : t[5:3];
    put_tag(h, st ? pkt_tag : rnd17());
    exp_q.push_back(b);
  endtask

  task automatic make_beat();
    garbage_half(0);
    garbage_half(1);
    have_beat = 1'b0;
    if ($urandom % 5 == 0) return;
    if (rem == 0) begin
      if (pkts_left == 0) return;
      start_pkt();
      fill_half(0, 1'b1);
    end else fill_half(0, 1'b0);
    if (rem > 0) fill_half(1, 1'b0);
    else if (pkts_left > 0 && $urandom % 2 == 1) begin
      start_pkt();
      fill_half(1, 1'b1);
    end
    have_beat = 1'b1;
  endtask

  bit prev_stall, prev_pair;
  logic [255:0] prev_data;
  logic prev_sop, prev_eop;

  task automatic run_phase(input int npk, input int pct);
    pkts_left = npk;
    rdy_pct = pct;
    while (!done && (pkts_left > 0 || rem > 0 || have_beat || exp_q.size() > 0)) begin
      @(negedge clk);
      out_ready = (int'($urandom % 100) < rdy_pct);
      if (!have_beat) make_beat();
      #1;
      if (prev_pair) chk(!in_ready, "R3", "in_ready after two-half beat", 256'(in_ready), 0);
      if (prev_stall) begin
        chk(out_valid, "R8", "out_valid held", 256'(out_valid), 1);
        chk(out_data == prev_data && out_sop == prev_sop && out_eop == prev_eop,
            "R8", "outputs held", out_data, prev_data);
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R10", "extra output beat", out_data, 0);
        else begin
          beat_t e = exp_q.pop_front();
          chk(out_data == e.d, "R2", "data", out_data, e.d);
          chk(out_sop == e.s, "R4", "sop", 256'(out_sop), 256'(e.s));
          chk(out_eop == e.e, "R4", "eop", 256'(out_eop), 256'(e.e));
          chk(out_empty == e.emp, "R5", "empty", 256'(out_empty), 256'(e.emp));
          chk({out_region, out_pf, out_vf_active, out_vf_num} == e.tag,
              e.s ? "R6" : "R7", "tags",
              256'({out_region, out_pf, out_vf_active, out_vf_num}), 256'(e.tag));
        end
      end
      prev_pair  = in_ready && in_valid == 2'b11;
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      prev_sop   = out_sop;
      prev_eop   = out_eop;
      if (in_ready) have_beat = 1'b0;
      @(posedge clk);
    end
  endtask

  initial begin
    in_valid = 0; in_sop = 0; in_eop = 0; in_data = 0; in_empty = 0;
    in_region = 0; in_pf = 0; in_vf_active = 0; in_vf_num = 0; out_ready = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(!out_valid, "R1", "out_valid in reset", 256'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!out_valid, "R1", "out_valid after reset", 256'(out_valid), 0);
    chk(in_ready, "R1", "in_ready after reset", 256'(in_ready), 1);
    @(posedge clk);
    run_phase(300, 100);
    run_phase(300, 50);
    run_phase(300, 15);
    repeat (5) begin
      @(negedge clk); #1;
      chk(!out_valid, "R10", "no output from idle or invalid halves", 256'(out_valid), 0);
    end
    chk(exp_q.size() == 0, "R9", "all halves delivered", 256'(exp_q.size()), 0);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R9 watchdog expired actual=%0d expected=0", exp_q.size());
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule